// File: doc/BRIEF.md
# Two-Channel Serial Receive Queue and Interrupt Status

This block keeps the receive-side state of a two-channel serial controller. Each channel owns a circular byte queue. Bytes arriving on a shared receive stream, tagged with a channel number, are pushed into that channel's queue. Reads of a channel's data port pop it. A register-access front end supplies the current contents of the configuration registers that matter here and pulses strobes for data-port reads, data-port writes and reads of the pending register. The block presents each channel's two status bytes, the head byte of each queue, a shared pending byte and a single interrupt line.

Interrupt control is centralised in channel A. Channel A's master-enable bit and its receive-mode field govern both channels. Only the transmit-interrupt enable is read per channel. All pending flags sit in one byte, and reading that byte, or reading either data port, clears all of it. A channel whose loopback bit is set copies every byte written to its data port back into its own receive queue.

Top module: `duo_serial_irq`

## Requirements
- R1: Each channel has its own circular queue that returns bytes in arrival order. The queue has DEPTH slots and holds at most DEPTH-1 bytes. Its pointers wrap from DEPTH-1 to 0. `rx_head[c]` shows the oldest byte whenever the queue is non-empty.
- R2: A push into a full queue is dropped and raises `ovf[c]` for one cycle, in the cycle after the push. A pop strobe on an empty queue is ignored. A push and a pop in the same cycle are judged on the occupancy before that cycle.
- R3: `rr0[c]` reads bit 0 = receive data available (queue non-empty) and bit 2 = 1 (transmitter always empty). All other bits read 0.
- R4: `rr1[c]` always reads 0.
- R5: `rr3` layout: bit 5 channel A receive pending, bit 4 channel A transmit pending, bit 3 channel A external pending, bit 2 channel B receive pending, bit 1 channel B transmit pending, bit 0 channel B external pending. The external bits and bits 7:6 always read 0.
- R6: The receive-pending bit of a channel becomes set at the next edge when all three of these hold at the current edge: `wr9_a` bit 3 (master enable) is 1, `wr1_cfg[0]` bits 4:3 are nonzero, and that channel's queue is non-empty. Channel B's own bits 4:3 have no effect.
- R7: A data-port write (`tx_wr`) on channel c sets c's transmit-pending bit at the next edge when master enable and `wr1_cfg[c]` bit 1 are both 1.
- R8: A cycle with `rr3_rd` or `data_rd` clears every bit of `rr3` at the next edge. The clear takes precedence over any set in the same cycle.
- R9: `irq` equals the master enable ANDed with the OR of three terms: (A transmit pending AND `wr1_cfg[0]` bit 1), (B transmit pending AND `wr1_cfg[1]` bit 1), and (either receive pending AND `wr1_cfg[0]` bits 4:3 nonzero). It follows the configuration inputs in the same cycle.
- R10: When `wr14_cfg[c]` bit 4 is 1, a data-port write on channel c pushes `tx_byte` into c's queue. If a stream byte for the same channel arrives in that cycle, the stream byte is dropped and `ovf[c]` is raised.
- R11: After reset both queues are empty and `rr3`, `ovf` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr9_a | input | 8 | Channel A master-control register (bit 3 master enable) |
| wr1_cfg | input | 2x8 | Per-channel interrupt-enable register, index 0 = channel A |
| wr14_cfg | input | 2x8 | Per-channel misc register (bit 4 loopback) |
| rx_valid | input | 1 | Receive stream byte strobe |
| rx_chan | input | 1 | Receive stream channel (0 = A) |
| rx_byte | input | 8 | Receive stream byte |
| tx_wr | input | 1 | Data-port write strobe |
| tx_chan | input | 1 | Data-port write channel |
| tx_byte | input | 8 | Data-port write byte |
| data_rd | input | 1 | Data-port read strobe (pops queue, clears rr3) |
| rd_chan | input | 1 | Data-port read channel |
| rr3_rd | input | 1 | Pending-register read strobe |
| rr0 | output | 2x8 | Per-channel status byte |
| rr1 | output | 2x8 | Per-channel error status byte |
| rr3 | output | 8 | Shared pending byte |
| rx_head | output | 2x8 | Oldest byte of each queue |
| ovf | output | 2 | Per-channel overrun pulse |
| irq | output | 1 | Interrupt request |

## Verification
A behavioural model with one byte queue per channel predicts every output on every cycle. The receive path is tried with short bursts on both channels, with a fill to full capacity followed by an extra push, and with push-while-popping at the full boundary. It is also tried with a drain and refill that crosses the pointer wrap. Together these separate ordering faults from capacity and wrap faults. The interrupt path is tried with the master enable off and then on, and with each receive-mode encoding. Transmit writes are issued with the enable present and absent per channel. Clears are issued alone and in the same cycle as a set, which tells precedence faults apart from gating faults. Loopback is tried alone and colliding with a stream byte, which checks the drop rule.

// File: rtl/sq_pkg.sv
package sq_pkg;
    localparam int unsigned NCH      = 2;
    localparam int unsigned BW       = 8;
    localparam int unsigned MIE_BIT  = 3;
    localparam int unsigned TXIE_BIT = 1;
    localparam int unsigned RXM_LO   = 3;
    localparam int unsigned RXM_HI   = 4;
    localparam int unsigned LOOP_BIT = 4;

    typedef struct packed {
        logic [1:0] spare;
        logic       rx_a;
        logic       tx_a;
        logic       ext_a;
        logic       rx_b;
        logic       tx_b;
        logic       ext_b;
    } pend_t;

    function automatic logic [BW-1:0] status_byte(input logic avail);
        return {5'b0, 1'b1, 1'b0, avail};
    endfunction
endpackage

// File: rtl/rx_ring.sv
module rx_ring #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         avail,
    output logic [W-1:0] head,
    output logic         ovf
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          full, empty;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty = (wptr == rptr);
    assign full  = (adv(wptr) == rptr);
    assign avail = !empty;
    assign head  = mem[rptr];

    always_ff @(posedge clk) begin
        if (push && !full) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            ovf  <= 1'b0;
        end else begin
            ovf <= push && full;
            if (push && !full) wptr <= adv(wptr);
            if (pop && !empty) rptr <= adv(rptr);
        end
    end

    assert_full_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> (wptr == $past(wptr)));
    assert_empty_pop_R2: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |=> (rptr == $past(rptr)));
endmodule

// File: rtl/pend_ctl.sv
module pend_ctl
    import sq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           mie,
    input  logic           rxie,
    input  logic [NCH-1:0] txie,
    input  logic [NCH-1:0] avail,
    input  logic [NCH-1:0] tx_hit,
    input  logic           clr,
    output pend_t          pend,
    output logic           irq
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend <= '0;
        end else begin
            pend.rx_a <= pend.rx_a | (mie & rxie & avail[0]);
            pend.rx_b <= pend.rx_b | (mie & rxie & avail[1]);
            pend.tx_a <= pend.tx_a | (mie & tx_hit[0] & txie[0]);
            pend.tx_b <= pend.tx_b | (mie & tx_hit[1] & txie[1]);
        end
    end

    assign irq = mie & ((pend.tx_a & txie[0]) | (pend.tx_b & txie[1]) |
                        (rxie & (pend.rx_a | pend.rx_b)));

    assert_clear_all_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pend == '0));
    assert_tx_set_R7: assert property (@(posedge clk) disable iff (rst)
        (!clr && mie && tx_hit[1] && txie[1]) |=> pend.tx_b);
    assert_rx_set_R6: assert property (@(posedge clk) disable iff (rst)
        (!clr && mie && rxie && avail[0]) |=> pend.rx_a);
endmodule

// File: rtl/duo_serial_irq.sv
module duo_serial_irq
    import sq_pkg::*;
#(
    parameter int unsigned DEPTH = 1024
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [BW-1:0]          wr9_a,
    input  logic [NCH-1:0][BW-1:0] wr1_cfg,
    input  logic [NCH-1:0][BW-1:0] wr14_cfg,
    input  logic                   rx_valid,
    input  logic                   rx_chan,
    input  logic [BW-1:0]          rx_byte,
    input  logic                   tx_wr,
    input  logic                   tx_chan,
    input  logic [BW-1:0]          tx_byte,
    input  logic                   data_rd,
    input  logic                   rd_chan,
    input  logic                   rr3_rd,
    output logic [NCH-1:0][BW-1:0] rr0,
    output logic [NCH-1:0][BW-1:0] rr1,
    output logic [BW-1:0]          rr3,
    output logic [NCH-1:0][BW-1:0] rx_head,
    output logic [NCH-1:0]         ovf,
    output logic                   irq
);
    logic [NCH-1:0] avail, txie, tx_hit;
    logic           mie, rxie;
    pend_t          pend;

    assign mie  = wr9_a[MIE_BIT];
    assign rxie = |wr1_cfg[0][RXM_HI:RXM_LO];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic lp, st, ring_ovf, col_q;

        assign lp        = tx_wr && (int'(tx_chan) == c) && wr14_cfg[c][LOOP_BIT];
        assign st        = rx_valid && (int'(rx_chan) == c);
        assign tx_hit[c] = tx_wr && (int'(tx_chan) == c);
        assign txie[c]   = wr1_cfg[c][TXIE_BIT];

        rx_ring #(.DEPTH(DEPTH), .W(BW)) u_ring (
            .clk   (clk),
            .rst   (rst),
            .push  (lp | st),
            .din   (lp ? tx_byte : rx_byte),
            .pop   (data_rd && (int'(rd_chan) == c)),
            .avail (avail[c]),
            .head  (rx_head[c]),
            .ovf   (ring_ovf)
        );

        always_ff @(posedge clk) begin
            if (rst) col_q <= 1'b0;
            else     col_q <= lp && st;
        end

        assign ovf[c] = ring_ovf | col_q;
        assign rr0[c] = status_byte(avail[c]);
        assign rr1[c] = '0;
    end

    pend_ctl u_pend (
        .clk    (clk),
        .rst    (rst),
        .mie    (mie),
        .rxie   (rxie),
        .txie   (txie),
        .avail  (avail),
        .tx_hit (tx_hit),
        .clr    (rr3_rd | data_rd),
        .pend   (pend),
        .irq    (irq)
    );

    assign rr3 = pend;

    assert_collide_ovf_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && rx_valid && (tx_chan == rx_chan) && wr14_cfg[tx_chan][LOOP_BIT])
        |=> ovf[$past(tx_chan)]);
endmodule

// File: tb/sim_duo_serial_irq.sv
module sim_duo_serial_irq;
    localparam int DEPTH = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0]      wr9_a = '0;
    logic [1:0][7:0] wr1_cfg = '0, wr14_cfg = '0;
    logic rx_valid = 0, rx_chan = 0, tx_wr = 0, tx_chan = 0, data_rd = 0, rd_chan = 0, rr3_rd = 0;
    logic [7:0] rx_byte = '0, tx_byte = '0;
    logic [1:0][7:0] rr0, rr1, rx_head;
    logic [7:0] rr3;
    logic [1:0] ovf;
    logic irq;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [7:0] q0[$], q1[$];
    logic [7:0] e_rr3 = '0;
    logic [1:0] e_ovf = '0;

    always #10 clk = ~clk;

    duo_serial_irq #(.DEPTH(DEPTH)) u0 (
        .clk, .rst, .wr9_a, .wr1_cfg, .wr14_cfg, .rx_valid, .rx_chan, .rx_byte,
        .tx_wr, .tx_chan, .tx_byte, .data_rd, .rd_chan, .rr3_rd,
        .rr0, .rr1, .rr3, .rx_head, .ovf, .irq
    );

    function automatic int qsize(input int c);
        return (c == 0) ? q0.size() : q1.size();
    endfunction

    // Reference model, updated from the inputs in force at each edge
    always @(posedge clk) begin
        if (rst) begin
            q0.delete(); q1.delete(); e_rr3 <= '0; e_ovf <= '0;
        end else begin
            logic mie, rxie;
            logic [7:0] n3;
            logic [1:0] nov;
            mie  = wr9_a[3];
            rxie = (wr1_cfg[0][4:3] != 2'b00);
            n3 = e_rr3;
            if (rr3_rd || data_rd) n3 = '0;
            else begin
                if (mie && rxie && qsize(0) > 0) n3[5] = 1'b1;
                if (mie && rxie && qsize(1) > 0) n3[2] = 1'b1;
                if (tx_wr && mie && wr1_cfg[tx_chan][1]) n3[tx_chan ? 1 : 4] = 1'b1;
            end
            for (int c = 0; c < 2; c++) begin
                bit lp, st, full, pushes, pp;
                int sz;
                sz = qsize(c);
                lp = tx_wr && (int'(tx_chan) == c) && wr14_cfg[c][4];
                st = rx_valid && (int'(rx_chan) == c);
                full = (sz == DEPTH - 1);
                pushes = lp || st;
                pp = data_rd && (int'(rd_chan) == c) && sz > 0;
                nov[c] = (pushes && full) || (lp && st);
                if (pp) begin
                    if (c == 0) void'(q0.pop_front()); else void'(q1.pop_front());
                end
                if (pushes && !full) begin
                    if (c == 0) q0.push_back(lp ? tx_byte : rx_byte);
                    else        q1.push_back(lp ? tx_byte : rx_byte);
                end
            end
            e_rr3 <= n3;
            e_ovf <= nov;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %02h expected %02h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic rxie, e_irq;
            rxie = (wr1_cfg[0][4:3] != 2'b00);
            e_irq = wr9_a[3] && ((e_rr3[4] && wr1_cfg[0][1]) || (e_rr3[1] && wr1_cfg[1][1]) ||
                                 ((e_rr3[5] || e_rr3[2]) && rxie));
            for (int c = 0; c < 2; c++) begin
                chk("R3 rr0", rr0[c], {5'b0, 1'b1, 1'b0, (qsize(c) > 0)});
                chk("R4 rr1", rr1[c], 8'h00);
                if (qsize(c) > 0)
                    chk("R1 head", rx_head[c], (c == 0) ? q0[0] : q1[0]);
            end
            chk("R5/R6/R7/R8 rr3", rr3, e_rr3);
            chk("R2/R10 ovf", {6'b0, ovf}, {6'b0, e_ovf});
            chk("R9 irq", {7'b0, irq}, {7'b0, e_irq});
        end
    end

    task automatic nxt();
        @(posedge clk); #2;
        rx_valid = 0; tx_wr = 0; data_rd = 0; rr3_rd = 0;
    endtask

    task automatic rx(input logic ch, input logic [7:0] b);
        rx_valid = 1; rx_chan = ch; rx_byte = b; nxt();
    endtask

    task automatic tx(input logic ch, input logic [7:0] b);
        tx_wr = 1; tx_chan = ch; tx_byte = b; nxt();
    endtask

    task automatic rd(input logic ch);
        data_rd = 1; rd_chan = ch; nxt();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) nxt();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 0;
        @(negedge clk);
        // R11: reset state
        chk("R11 rr3", rr3, 8'h00);
        chk("R11 irq", {7'b0, irq}, 8'h00);
        chk("R11 ovf", {6'b0, ovf}, 8'h00);
        chk("R11 avail", {6'b0, rr0[1][0], rr0[0][0]}, 8'h00);
        #2;
        // R6: data present but master enable off
        rx(0, 8'h11); rx(0, 8'h22); rx(1, 8'h33); idle(2);
        wr1_cfg[0] = 8'h08; idle(2);
        // R6: master enable on, channel A mode gates both
        wr9_a = 8'h08; idle(3);
        // R8: data read clears, then pending re-arms
        rd(0); idle(3);
        // R6: channel B mode bits alone have no effect
        wr1_cfg[0] = 8'h02; wr1_cfg[1] = 8'h18; rr3_rd = 1; nxt(); idle(2);
        // R7: transmit pending per channel
        tx(0, 8'h44); idle(2);
        tx(1, 8'h45); idle(1);
        wr1_cfg[1] = 8'h02; tx(1, 8'h46); idle(2);
        // R8: clear wins over same-cycle set
        rr3_rd = 1; tx_wr = 1; tx_chan = 0; tx_byte = 8'h47; nxt(); idle(2);
        // R10: loopback, then loopback colliding with stream
        wr14_cfg[0] = 8'h10; tx(0, 8'h55); idle(1);
        tx_wr = 1; tx_chan = 0; tx_byte = 8'h56; rx_valid = 1; rx_chan = 0; rx_byte = 8'h66; nxt(); idle(2);
        wr14_cfg[1] = 8'h10; tx(1, 8'h57); wr14_cfg = '0; idle(1);
        // R2: drain both, including pops of empty queues
        for (int i = 0; i < 6; i++) begin rd(0); rd(1); end
        idle(2);
        // R1/R2: fill channel A to capacity, overflow, push+pop at full
        wr9_a = 8'h00;
        for (int i = 0; i < DEPTH - 1; i++) rx(0, 8'(i * 7 + 3));
        rx(0, 8'hEE); idle(1);
        rx_valid = 1; rx_chan = 0; rx_byte = 8'hDD; data_rd = 1; rd_chan = 0; nxt();
        rx(0, 8'hCC); idle(1);
        // R1: drain then refill across the wrap
        for (int i = 0; i < DEPTH; i++) rd(0);
        for (int i = 0; i < 20; i++) rx(0, 8'(8'hA0 + i));
        // R6: other receive mode encoding
        wr9_a = 8'h08; wr1_cfg[0] = 8'h10; idle(2);
        for (int i = 0; i < 22; i++) rd(0);
        idle(3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule